// File: doc/BRIEF.md
# Frame-Synchronized Double Transmit Buffer

This block buffers outgoing data for one isochronous-style USB device endpoint. It holds two equal halves of 64 bytes each, 128 bytes in all, so each half holds one packet of the largest size. At any moment the CPU owns one half and loads it one byte per write. The USB side owns the other half and drains it when the host asks for a packet.

The halves trade roles only when a start-of-frame strobe arrives. On that strobe, the bytes the CPU has written become one fixed packet, and that packet is presented to the USB side with a ready flag and a byte count. Two clear inputs are provided. One empties both halves. The other empties only the half the CPU owns and leaves a packet that is waiting on the USB side as it is. A sticky overflow flag reports bytes that were dropped. A sticky missed flag reports a packet that was discarded before it was fully read.

Top module: `sof_pingpong_txbuf`

## Requirements
- R1: After reset, `usb_ready`, `usb_count`, `overflow` and `missed_pkt` are all 0.
- R2: Only bits [7:0] of `cpu_wr_data` are stored. Bits [31:8] have no effect on the byte the USB side later reads.
- R3: A `sof` pulse with at least one byte in the CPU half commits those bytes. From the next cycle, `usb_ready` is 1 and `usb_count` equals the number of bytes written.
- R4: A `sof` pulse when the CPU half is empty commits nothing and swaps nothing. It releases the USB half, so `usb_ready` is 0 and `usb_count` is 0 afterwards.
- R5: Writes beyond 64 bytes into one half are dropped, and `usb_count` never exceeds 64. A dropped write sets `overflow`, which stays 1 until `clr_cpu` or `clr_all`.
- R6: Each `usb_rd_en` cycle while ready advances to the next byte. After the final byte is read, `usb_ready` falls to 0 and `usb_count` falls to 0.
- R7: A `sof` that commits a new packet while the previous one is not fully read discards the old packet, presents the new one, and sets the sticky `missed_pkt` flag.
- R8: `clr_all` empties both halves and clears `usb_ready`, `usb_count`, `overflow` and `missed_pkt` in one cycle. A partly written packet is lost, so a following `sof` commits nothing.
- R9: `clr_cpu` empties only the CPU half. A packet waiting on the USB side keeps its ready flag, its count and its data.
- R10: When a clear comes in the same cycle as a write or a `sof`, the clear takes priority. The write is dropped and no swap occurs.
- R11: A write in the same cycle as a `sof` is included in the committed packet as its last byte.
- R12: Bytes are read out in the order they were written. The CPU may fill its half while the USB side reads the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_data | input | 32 | CPU write word; only bits [7:0] are used |
| sof | input | 1 | Start-of-frame strobe |
| clr_all | input | 1 | Empty both halves and clear the flags |
| clr_cpu | input | 1 | Empty the CPU-owned half and clear overflow |
| usb_rd_en | input | 1 | Advance to the next byte of the ready packet |
| usb_rd_data | output | 8 | Current byte of the ready packet |
| usb_ready | output | 1 | A committed packet is waiting to be read |
| usb_count | output | 7 | Byte count of the ready packet (0 when not ready) |
| overflow | output | 1 | Sticky: a write was dropped because the half was full |
| missed_pkt | output | 1 | Sticky: an unread packet was discarded by a frame start |

## Verification
The collisions that matter most are a CPU write landing in the same cycle as a frame start, and a clear landing in the same cycle as either of them. The bench drives each pair within one clock cycle. In the write-plus-frame case it expects the committed count to include the extra byte and checks that byte's value on readout. In the clear case it expects no packet at all, and then confirms with a second frame start that the dropped write left nothing behind.

// File: rtl/sof_pingpong_txbuf.sv
module sof_pingpong_txbuf #(
  parameter int PKT_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr_en,
  input  logic [31:0] cpu_wr_data,
  input  logic        sof,
  input  logic        clr_all,
  input  logic        clr_cpu,
  input  logic        usb_rd_en,
  output logic [7:0]  usb_rd_data,
  output logic        usb_ready,
  output logic [$clog2(PKT_BYTES):0] usb_count,
  output logic        overflow,
  output logic        missed_pkt
);
  localparam int AW = $clog2(PKT_BYTES);
  localparam int CW = AW + 1;

  logic [7:0]    mem [2*PKT_BYTES];
  logic [CW-1:0] cnt [2];
  logic          cpu_sel, rdy, ovf_q, miss_q;
  logic [AW-1:0] rptr;

  wire unused_hi = ^cpu_wr_data[31:8];

  wire [CW-1:0] cpu_cnt    = cnt[cpu_sel];
  wire [CW-1:0] usb_cnt    = cnt[~cpu_sel];
  wire          room       = cpu_cnt < CW'(PKT_BYTES);
  wire          clr_any    = clr_all | clr_cpu;
  wire          wr_ok      = cpu_wr_en & room & ~clr_any;
  wire [CW-1:0] cpu_cnt_nx = cpu_cnt + CW'(wr_ok);
  wire          do_sof     = sof & ~clr_any;
  wire          swap       = do_sof & (cpu_cnt_nx != '0);
  wire          rd_ok      = usb_rd_en & rdy & ~clr_all & ~do_sof;
  wire          last_rd    = rd_ok & ((CW'(rptr) + CW'(1)) == usb_cnt);

  always_ff @(posedge clk)
    if (wr_ok) mem[{cpu_sel, cpu_cnt[AW-1:0]}] <= cpu_wr_data[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt[0] <= '0; cnt[1] <= '0; cpu_sel <= 1'b0;
      rptr <= '0; rdy <= 1'b0; ovf_q <= 1'b0; miss_q <= 1'b0;
    end else if (clr_all) begin
      cnt[0] <= '0; cnt[1] <= '0;
      rptr <= '0; rdy <= 1'b0; ovf_q <= 1'b0; miss_q <= 1'b0;
    end else begin
      if (clr_cpu) begin
        cnt[cpu_sel] <= '0;
        ovf_q <= 1'b0;
      end else if (cpu_wr_en && !room) begin
        ovf_q <= 1'b1;
      end

      if (swap) begin
        cpu_sel      <= ~cpu_sel;
        cnt[cpu_sel] <= cpu_cnt_nx;
        cnt[~cpu_sel] <= '0;
        rptr         <= '0;
      end else if (wr_ok) begin
        cnt[cpu_sel] <= cpu_cnt_nx;
      end

      if (do_sof) begin
        if (rdy) miss_q <= 1'b1;
        rdy <= swap;
      end else if (rd_ok) begin
        rptr <= rptr + AW'(1);
        if (last_rd) rdy <= 1'b0;
      end
    end
  end

  assign usb_rd_data = mem[{~cpu_sel, rptr}];
  assign usb_ready   = rdy;
  assign usb_count   = rdy ? usb_cnt : '0;
  assign overflow    = ovf_q;
  assign missed_pkt  = miss_q;

  p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !clr_any && (cpu_cnt != '0 || cpu_wr_en)) |=> usb_ready);

  p_empty_sof_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !clr_any && cpu_cnt == '0 && !cpu_wr_en) |=> (!usb_ready && usb_count == '0));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    usb_count <= CW'(PKT_BYTES));

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_any) |=> overflow);

  p_missed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !clr_any && usb_ready) |=> missed_pkt);

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (!usb_ready && !overflow && !missed_pkt && usb_count == '0));

  p_clr_cpu_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cpu && !clr_all && !usb_rd_en) |=> ($stable(usb_ready) && $stable(usb_count)));
endmodule

// File: tb/sof_pingpong_txbuf_test.sv
module sof_pingpong_txbuf_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr_en = 0, sof = 0, clr_all = 0, clr_cpu = 0, usb_rd_en = 0;
  logic [31:0] cpu_wr_data = '0;
  logic [7:0] usb_rd_data;
  logic usb_ready, overflow, missed_pkt;
  logic [6:0] usb_count;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  sof_pingpong_txbuf uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit w, bit [7:0] b, bit s, bit ca, bit cc);
    cpu_wr_en = w; cpu_wr_data = {24'hA5C3E1, b}; sof = s; clr_all = ca; clr_cpu = cc;
    @(negedge clk);
    cpu_wr_en = 0; sof = 0; clr_all = 0; clr_cpu = 0;
  endtask

  task automatic wr(bit [7:0] b);  cyc(1, b, 0, 0, 0); endtask
  task automatic pulse_sof();      cyc(0, 0, 1, 0, 0); endtask
  task automatic wipe();           cyc(0, 0, 0, 1, 0); endtask

  task automatic rd(string req, bit [7:0] exp);
    chk(req, usb_rd_data, exp);
    usb_rd_en = 1; @(negedge clk); usb_rd_en = 0;
  endtask

  task automatic t_reset();
    chk("R1 ready", usb_ready, 0);
    chk("R1 count", usb_count, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 missed", missed_pkt, 0);
  endtask

  task automatic t_basic();
    wipe();
    for (int i = 0; i < 5; i++) wr(8'h10 + 8'(i));
    chk("R3 ready before sof", usb_ready, 0);
    pulse_sof();
    chk("R3 ready", usb_ready, 1);
    chk("R3 count", usb_count, 5);
    for (int i = 0; i < 5; i++) rd("R2/R12 data", 8'h10 + 8'(i));
    chk("R6 ready after last", usb_ready, 0);
    chk("R6 count after last", usb_count, 0);
  endtask

  task automatic t_empty_sof();
    wipe();
    wr(8'h01); pulse_sof();
    chk("R4 setup ready", usb_ready, 1);
    pulse_sof();
    chk("R4 ready", usb_ready, 0);
    chk("R4 count", usb_count, 0);
  endtask

  task automatic t_overflow();
    wipe();
    for (int i = 0; i < 64; i++) wr(8'(i));
    chk("R5 no overflow at 64", overflow, 0);
    for (int i = 0; i < 6; i++) wr(8'hEE);
    chk("R5 overflow set", overflow, 1);
    pulse_sof();
    chk("R5 count capped", usb_count, 64);
    chk("R5 overflow sticky", overflow, 1);
    for (int i = 0; i < 64; i++) rd("R5 data", 8'(i));
    cyc(0, 0, 0, 0, 1);
    chk("R5 overflow cleared", overflow, 0);
  endtask

  task automatic t_missed();
    wipe();
    wr(8'h31); wr(8'h32); wr(8'h33); pulse_sof();
    wr(8'h41); wr(8'h42); pulse_sof();
    chk("R7 missed", missed_pkt, 1);
    chk("R7 count", usb_count, 2);
    rd("R7 new data", 8'h41);
  endtask

  task automatic t_clr_all();
    wipe();
    wr(8'h51); wr(8'h52); wr(8'h53); pulse_sof();
    wr(8'h61); wr(8'h62); pulse_sof();
    wr(8'h71); wr(8'h72);
    wipe();
    chk("R8 ready", usb_ready, 0);
    chk("R8 count", usb_count, 0);
    chk("R8 missed", missed_pkt, 0);
    pulse_sof();
    chk("R8 partial lost", usb_ready, 0);
  endtask

  task automatic t_clr_cpu();
    wipe();
    wr(8'hA0); wr(8'hA1); wr(8'hA2); pulse_sof();
    for (int i = 0; i < 5; i++) wr(8'hB0 + 8'(i));
    cyc(0, 0, 0, 0, 1);
    chk("R9 ready kept", usb_ready, 1);
    chk("R9 count kept", usb_count, 3);
    chk("R9 data kept", usb_rd_data, 8'hA0);
    wr(8'hC0); wr(8'hC1); pulse_sof();
    chk("R9 cpu half emptied", usb_count, 2);
    rd("R9 new data", 8'hC0);
  endtask

  task automatic t_prio();
    wipe();
    wr(8'h11); wr(8'h12);
    cyc(1, 8'h13, 1, 0, 1);
    chk("R10 clr_cpu beats sof", usb_ready, 0);
    pulse_sof();
    chk("R10 write dropped", usb_ready, 0);
    wr(8'h21); wr(8'h22); pulse_sof();
    wr(8'h23);
    cyc(1, 8'h24, 1, 1, 0);
    chk("R10 clr_all beats sof", usb_ready, 0);
    chk("R10 clr_all missed", missed_pkt, 0);
  endtask

  task automatic t_wr_sof();
    wipe();
    wr(8'h81); wr(8'h82);
    cyc(1, 8'h83, 1, 0, 0);
    chk("R11 count", usb_count, 3);
    rd("R11 data0", 8'h81); rd("R11 data1", 8'h82); rd("R11 data2", 8'h83);
    chk("R11 released", usb_ready, 0);
  endtask

  task automatic t_pingpong();
    wipe();
    wr(8'h90); wr(8'h91); wr(8'h92); pulse_sof();
    rd("R12 data0", 8'h90); wr(8'hD0);
    rd("R12 data1", 8'h91); wr(8'hD1);
    rd("R12 data2", 8'h92); wr(8'hD2); wr(8'hD3);
    chk("R12 released", usb_ready, 0);
    pulse_sof();
    chk("R12 count", usb_count, 4);
    chk("R12 no miss", missed_pkt, 0);
    for (int i = 0; i < 4; i++) rd("R12 data", 8'hD0 + 8'(i));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_empty_sof();
    t_overflow();
    t_missed();
    t_clr_all();
    t_clr_cpu();
    t_prio();
    t_wr_sof();
    t_pingpong();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule